// File: doc/BRIEF.md
# Nonvolatile Memory Write Controller

This block sits between a byte-wide register bus and three behavioural nonvolatile stores: a program store, a data store and a configuration store. Software loads a byte latch and an address pointer, then issues table-write strobes. Each strobe drops the latch byte into one of eight holding slots, chosen by the pointer's three low bits. A later start command copies the eight slots into one aligned 8-byte block of the selected store, or fills a 64-byte program row with ones. The command runs under an internal programming timer.

A command starts only when three conditions hold. The enable bit must already be set. The two key bytes must have been written to a storage-less key register. The start bit must then be written with no other bus write in between. The start bit can only be set by software and is cleared by hardware when the command completes. Completion also raises a flag that software clears. An error bit stays high after a reset that cuts a command short. A side read port lets the stores be inspected.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: After reset, the control register (offset 0), latch (offset 2) and pointer low byte (offset 3) read 0, and `irq_done` is 0.
- R2: The register map has six offsets: 0 control, 1 key, 2 latch, 3 pointer low, 4 pointer high, 5 table-write strobe. The latch and both pointer bytes read back what was written. The key register always reads 0x00.
- R3: Control bits are: bit0 start, bit1 enable, bit2 erase-arm, bit3 error (read-only), bit4 program select, bit5 configuration select, bit6 done. A start write (bit0 = 1) is accepted only if the two bus writes just before it were 0x55 and then 0xAA to the key register. Any other order, value or intervening bus write makes it ignored.
- R4: A start write is ignored unless the enable bit was already set before that write.
- R5: Writing 0 to the start bit never clears it. The start bit reads 1 for exactly PROG_CYCLES cycles after an accepted start, then reads 0.
- R6: A strobe write (offset 5) stores the latch into the holding slot indexed by pointer bits [2:0]. Strobes while busy are ignored.
- R7: A write command copies holding slots 0..7 to addresses B..B+7, where B is the pointer with bits [2:0] cleared, taken modulo the target size. Configuration select set picks the configuration store whatever the program select bit is. Otherwise program select 1 picks the program store and 0 picks the data store.
- R8: With erase-arm set, the command instead sets all 64 bytes of the 64-aligned program row that holds the pointer to 0xFF. Other rows are untouched.
- R9: The error bit is 1 from the start of a command until its normal completion. A reset during a command leaves it at 1 and leaves the stores unchanged. The next normal completion clears it.
- R10: On completion the done bit and `irq_done` go to 1. Writing the done bit as 1 has no effect. A control write with done = 0 clears it.
- R11: After any completed command all holding slots read as 0xFF, so a write with no strobes stores 0xFF bytes.
- R12: Start writes during a command are ignored and do not extend it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_done | output | 1 | Completion interrupt flag |
| rd_space | input | 2 | Inspection store: 0 data, 1 program, 2 configuration |
| rd_addr | input | 16 | Inspection byte address |
| rd_data | output | 8 | Inspection byte |

## Verification
Every cycle, the assertions check several invariants. The start bit survives writes of zero while the timer runs. A command begins only after an unlock and with enable set. The error bit stays high through a command. The done flag rises only as a command ends. The key register reads zero. The holding slots stay frozen during a command and return to ones after it. Only the bench scenarios can show which store and block receive the data and the exact row an erase clears. They also show that bad key orders are rejected, that a command cut short by reset leaves the stores untouched, and that start bits and strobes issued mid-command leave the committed data and the completion time unchanged.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;

    localparam int NVM_PTR_W  = 16;
    localparam int HOLD_N     = 8;
    localparam int ROW_BYTES  = 64;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_KEY   = 3'd1;
    localparam logic [2:0] OFS_LATCH = 3'd2;
    localparam logic [2:0] OFS_PTRL  = 3'd3;
    localparam logic [2:0] OFS_PTRH  = 3'd4;
    localparam logic [2:0] OFS_STRB  = 3'd5;

    localparam int CB_GO    = 0;
    localparam int CB_WEN   = 1;
    localparam int CB_ERASE = 2;
    localparam int CB_ERR   = 3;
    localparam int CB_PROG  = 4;
    localparam int CB_CFG   = 5;
    localparam int CB_DONE  = 6;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        SP_DATA = 2'd0,
        SP_PROG = 2'd1,
        SP_CFG  = 2'd2
    } space_e;

    typedef struct packed {
        logic                 erase;
        space_e               space;
        logic [NVM_PTR_W-1:0] addr;
    } op_t;

    function automatic space_e pick_space(input logic prog_sel, input logic cfg_sel);
        if (cfg_sel)       return SP_CFG;
        else if (prog_sel) return SP_PROG;
        else               return SP_DATA;
    endfunction

endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       any_wr,
    input  logic       key_wr,
    input  logic [7:0] wdata,
    output logic       armed
);
    typedef enum logic [1:0] {U_IDLE, U_ONE, U_TWO} ustate_e;
    ustate_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= U_IDLE;
        end else if (any_wr) begin
            if (key_wr && wdata == KEY_FIRST)
                st_q <= U_ONE;
            else if (key_wr && st_q == U_ONE && wdata == KEY_SECOND)
                st_q <= U_TWO;
            else
                st_q <= U_IDLE;
        end
    end

    assign armed = (st_q == U_TWO);

    // R3: arming needs the second key on the write right after the first
    assert_arm_order_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(key_wr && wdata == KEY_SECOND));
endmodule

// File: rtl/nvm_hold_buf.sv
module nvm_hold_buf
    import nvm_wr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [2:0]            idx,
    input  logic [7:0]            din,
    input  logic                  refill,
    output logic [HOLD_N*8-1:0]   flat
);
    logic [7:0] slot_q [HOLD_N];

    always_ff @(posedge clk) begin
        if (rst || refill) begin
            for (int i = 0; i < HOLD_N; i++) slot_q[i] <= 8'hFF;
        end else if (wr_en) begin
            slot_q[idx] <= din;
        end
    end

    for (genvar g = 0; g < HOLD_N; g++) begin : g_flat
        assign flat[8*g +: 8] = slot_q[g];
    end

    // R11: slots read as all ones right after a completed command
    assert_refill_ones_R11: assert property (@(posedge clk) disable iff (rst)
        refill |=> (flat == '1));
endmodule

// File: rtl/nvm_array.sv
module nvm_array
    import nvm_wr_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter bit ERASABLE = 1'b0
) (
    input  logic                  clk,
    input  logic                  wr_blk,
    input  logic                  er_row,
    input  logic [NVM_PTR_W-1:0]  addr,
    input  logic [HOLD_N*8-1:0]   blk_data,
    input  logic [NVM_PTR_W-1:0]  rd_addr,
    output logic [7:0]            rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] blk_base;
    logic [AW-1:0] row_base;

    assign blk_base = addr[AW-1:0] & ~AW'(HOLD_N - 1);
    assign row_base = addr[AW-1:0] & ~AW'(ROW_BYTES - 1);

    always_ff @(posedge clk) begin
        if (wr_blk) begin
            for (int i = 0; i < HOLD_N; i++)
                mem[blk_base | AW'(i)] <= blk_data[8*i +: 8];
        end else if (er_row && ERASABLE) begin
            for (int i = 0; i < ROW_BYTES; i++)
                mem[row_base + AW'(i)] <= 8'hFF;
        end
    end

    assign rd_data = mem[rd_addr[AW-1:0]];
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
    import nvm_wr_pkg::*;
#(
    parameter int PROG_BYTES  = 256,
    parameter int DATA_BYTES  = 64,
    parameter int CFG_BYTES   = 16,
    parameter int PROG_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [2:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  irq_done,
    input  logic [1:0]            rd_space,
    input  logic [NVM_PTR_W-1:0]  rd_addr,
    output logic [7:0]            rd_data
);
    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;

    logic wr, wr_ctrl, go_req, start, finish, armed;
    logic wen_q, erase_q, prog_q, cfg_q, done_q, busy_q;
    logic err_q = 1'b0;
    logic [CNT_W-1:0]     cnt_q;
    logic [7:0]           latch_q;
    logic [NVM_PTR_W-1:0] ptr_q;
    op_t                  op_q;
    logic [HOLD_N*8-1:0]  hold_flat;
    logic [7:0]           rd_prog, rd_dat, rd_cfg;

    assign wr      = bus_en && bus_we;
    assign wr_ctrl = wr && bus_addr == OFS_CTRL;
    assign go_req  = wr_ctrl && bus_wdata[CB_GO];
    assign start   = go_req && armed && wen_q && !busy_q;
    assign finish  = busy_q && cnt_q == '0;

    nvm_unlock u_unlock (
        .clk(clk), .rst(rst), .any_wr(wr),
        .key_wr(wr && bus_addr == OFS_KEY), .wdata(bus_wdata), .armed(armed)
    );

    nvm_hold_buf u_hold (
        .clk(clk), .rst(rst),
        .wr_en(wr && bus_addr == OFS_STRB && !busy_q),
        .idx(ptr_q[2:0]), .din(latch_q), .refill(finish), .flat(hold_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wen_q <= 1'b0; erase_q <= 1'b0; prog_q <= 1'b0; cfg_q <= 1'b0;
            done_q <= 1'b0; busy_q <= 1'b0; cnt_q <= '0;
            latch_q <= '0; ptr_q <= '0; op_q <= '0;
            if (busy_q) err_q <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                wen_q   <= bus_wdata[CB_WEN];
                erase_q <= bus_wdata[CB_ERASE];
                prog_q  <= bus_wdata[CB_PROG];
                cfg_q   <= bus_wdata[CB_CFG];
                if (!bus_wdata[CB_DONE]) done_q <= 1'b0;
            end
            if (wr && bus_addr == OFS_LATCH) latch_q <= bus_wdata;
            if (wr && bus_addr == OFS_PTRL)  ptr_q[7:0] <= bus_wdata;
            if (wr && bus_addr == OFS_PTRH)  ptr_q[NVM_PTR_W-1:8] <= bus_wdata;
            if (start) begin
                busy_q <= 1'b1;
                err_q  <= 1'b1;
                cnt_q  <= CNT_W'(PROG_CYCLES - 1);
                op_q   <= '{erase: erase_q, space: pick_space(prog_q, cfg_q), addr: ptr_q};
            end else if (finish) begin
                busy_q <= 1'b0;
                err_q  <= 1'b0;
                done_q <= 1'b1;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    nvm_array #(.DEPTH(PROG_BYTES), .ERASABLE(1'b1)) u_prog (
        .clk(clk), .wr_blk(finish && !op_q.erase && op_q.space == SP_PROG),
        .er_row(finish && op_q.erase), .addr(op_q.addr), .blk_data(hold_flat),
        .rd_addr(rd_addr), .rd_data(rd_prog)
    );
    nvm_array #(.DEPTH(DATA_BYTES), .ERASABLE(1'b0)) u_data (
        .clk(clk), .wr_blk(finish && !op_q.erase && op_q.space == SP_DATA),
        .er_row(1'b0), .addr(op_q.addr), .blk_data(hold_flat),
        .rd_addr(rd_addr), .rd_data(rd_dat)
    );
    nvm_array #(.DEPTH(CFG_BYTES), .ERASABLE(1'b0)) u_cfg (
        .clk(clk), .wr_blk(finish && !op_q.erase && op_q.space == SP_CFG),
        .er_row(1'b0), .addr(op_q.addr), .blk_data(hold_flat),
        .rd_addr(rd_addr), .rd_data(rd_cfg)
    );

    always_comb begin
        case (rd_space)
            2'd1:    rd_data = rd_prog;
            2'd2:    rd_data = rd_cfg;
            default: rd_data = rd_dat;
        endcase
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = {1'b0, done_q, cfg_q, prog_q, err_q, erase_q, wen_q, busy_q};
            OFS_LATCH: bus_rdata = latch_q;
            OFS_PTRL:  bus_rdata = ptr_q[7:0];
            OFS_PTRH:  bus_rdata = ptr_q[NVM_PTR_W-1:8];
            default:   bus_rdata = 8'h00;
        endcase
    end

    assign irq_done = done_q;

    // R5: a zero written to the start bit mid-command does not end it
    assert_go_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0 && wr_ctrl && !bus_wdata[CB_GO]) |=> busy_q);
    // R3 / R4: a command begins only after unlock with enable already set
    assert_start_gated_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(armed && wen_q && go_req));
    // R9: error bit high throughout a command
    assert_err_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> err_q);
    // R10: done rises only as a command ends
    assert_done_end_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $fell(busy_q));
    // R2: key register has no storage
    assert_key_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_KEY) |-> (bus_rdata == 8'h00));
    // R6: holding slots frozen while the timer runs
    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> $stable(hold_flat));
endmodule

// File: tb/nvm_wr_ctrl_bench.sv
module nvm_wr_ctrl_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int PROG_CYCLES = 16;

    localparam logic [2:0] A_CTRL = 3'd0, A_KEY = 3'd1, A_LATCH = 3'd2,
                           A_PTRL = 3'd3, A_PTRH = 3'd4, A_STRB = 3'd5;
    localparam logic [7:0] C_GO = 8'h01, C_WEN = 8'h02, C_ERASE = 8'h04, C_ERR = 8'h08,
                           C_PROG = 8'h10, C_CFG = 8'h20, C_DONE = 8'h40;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata, rd_data;
    logic        irq_done;
    logic [1:0]  rd_space = '0;
    logic [15:0] rd_addr = '0;
    int n_checks = 0, n_errors = 0;

    typedef struct {
        string       req;
        logic [1:0]  sp;
        logic [15:0] a;
        logic [7:0]  v;
    } item_t;
    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_wr_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_nvm_wr_ctrl (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_done(irq_done),
        .rd_space(rd_space), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(a, d);
        chk(req, d, exp);
    endtask

    task automatic expect_mem(input string req, input logic [1:0] sp,
                              input logic [15:0] a, input logic [7:0] v);
        item_t it;
        it.req = req; it.sp = sp; it.a = a; it.v = v;
        sbq.push_back(it);
    endtask

    task automatic drain();
        wait (sbq.size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expected bytes and compares them at the inspection port
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                rd_space = it.sp; rd_addr = it.a;
                #1 chk(it.req, rd_data, it.v);
            end
        end
    end

    task automatic fill_hold(input logic [7:0] base);
        for (int i = 0; i < 8; i++) begin
            bus_write(A_PTRL, 8'(i));
            bus_write(A_LATCH, base + 8'(i));
            bus_write(A_STRB, 8'h00);
        end
    endtask

    task automatic start_op(input logic [7:0] ctrl, input logic [15:0] ptr);
        bus_write(A_PTRL, ptr[7:0]);
        bus_write(A_PTRH, ptr[15:8]);
        bus_write(A_CTRL, ctrl);
        bus_write(A_KEY, 8'h55);
        bus_write(A_KEY, 8'hAA);
        bus_write(A_CTRL, ctrl | C_GO);
    endtask

    task automatic wait_op();
        repeat (PROG_CYCLES) @(negedge clk);
    endtask

    initial begin
        repeat (PROG_CYCLES * 12000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL R5 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_reg("R1 ctrl", A_CTRL, 8'h00);
        chk_reg("R1 latch", A_LATCH, 8'h00);
        chk_reg("R1 ptrl", A_PTRL, 8'h00);
        chk("R1 irq", {7'd0, irq_done}, 8'h00);

        // R2 register readback and key register
        bus_write(A_LATCH, 8'hA5);
        chk_reg("R2 latch", A_LATCH, 8'hA5);
        bus_write(A_PTRH, 8'h12);
        chk_reg("R2 ptrh", A_PTRH, 8'h12);
        bus_write(A_KEY, 8'h55);
        chk_reg("R2 key", A_KEY, 8'h00);

        // R5 / R7 data write with exact timing
        fill_hold(8'h10);
        start_op(C_WEN, 16'h0008);
        chk_reg("R5 go set", A_CTRL, C_WEN | C_GO | C_ERR);
        repeat (PROG_CYCLES - 1) @(negedge clk);
        chk_reg("R5 go last", A_CTRL, C_WEN | C_GO | C_ERR);
        @(negedge clk);
        chk_reg("R5 go clear", A_CTRL, C_WEN | C_DONE);
        chk("R10 irq", {7'd0, irq_done}, 8'h01);
        for (int i = 0; i < 8; i++) expect_mem("R7 data", 2'd0, 16'(8 + i), 8'h10 + 8'(i));
        drain();

        // R10 done clear behaviour
        bus_write(A_CTRL, C_WEN | C_DONE);
        chk_reg("R10 done kept", A_CTRL, C_WEN | C_DONE);
        bus_write(A_CTRL, C_WEN);
        chk_reg("R10 done cleared", A_CTRL, C_WEN);
        chk("R10 irq low", {7'd0, irq_done}, 8'h00);

        // R11 write with no strobes stores ones
        start_op(C_WEN, 16'h0008);
        wait_op();
        for (int i = 0; i < 8; i++) expect_mem("R11 ones", 2'd0, 16'(8 + i), 8'hFF);
        drain();

        // R8 erase program row 0, then R7 program write
        start_op(C_WEN | C_ERASE | C_PROG, 16'h0005);
        wait_op();
        expect_mem("R8 row0 lo", 2'd1, 16'h0000, 8'hFF);
        expect_mem("R8 row0 hi", 2'd1, 16'h003F, 8'hFF);
        drain();
        fill_hold(8'h20);
        start_op(C_WEN | C_PROG, 16'h0013);
        wait_op();
        for (int i = 0; i < 8; i++) expect_mem("R7 prog", 2'd1, 16'(16 + i), 8'h20 + 8'(i));
        expect_mem("R7 prog after", 2'd1, 16'h0018, 8'hFF);
        expect_mem("R7 prog before", 2'd1, 16'h000F, 8'hFF);
        drain();

        // R7 configuration select overrides program select
        fill_hold(8'h30);
        start_op(C_WEN | C_PROG | C_CFG, 16'h0008);
        wait_op();
        for (int i = 0; i < 8; i++) expect_mem("R7 cfg", 2'd2, 16'(8 + i), 8'h30 + 8'(i));
        expect_mem("R7 cfg not prog", 2'd1, 16'h0008, 8'hFF);
        drain();
        bus_write(A_CTRL, C_WEN);

        // R3 bad key sequences, R4 enable clear
        bus_write(A_KEY, 8'h55); bus_write(A_KEY, 8'h00); bus_write(A_CTRL, C_WEN | C_GO);
        chk_reg("R3 wrong value", A_CTRL, C_WEN);
        bus_write(A_KEY, 8'hAA); bus_write(A_KEY, 8'h55); bus_write(A_CTRL, C_WEN | C_GO);
        chk_reg("R3 wrong order", A_CTRL, C_WEN);
        bus_write(A_KEY, 8'h55); bus_write(A_KEY, 8'hAA); bus_write(A_LATCH, 8'h01);
        bus_write(A_CTRL, C_WEN | C_GO);
        chk_reg("R3 intervening write", A_CTRL, C_WEN);
        bus_write(A_CTRL, 8'h00);
        bus_write(A_KEY, 8'h55); bus_write(A_KEY, 8'hAA); bus_write(A_CTRL, C_WEN | C_GO);
        chk_reg("R4 enable clear", A_CTRL, C_WEN);
        chk("R4 irq", {7'd0, irq_done}, 8'h00);

        // R5 / R6 / R12 disturbances during a command
        fill_hold(8'h40);
        start_op(C_WEN | C_PROG, 16'h0030);
        bus_write(A_CTRL, C_WEN | C_PROG);
        chk_reg("R5 zero ignored", A_CTRL, C_WEN | C_PROG | C_GO | C_ERR);
        bus_write(A_PTRL, 8'h00);
        bus_write(A_LATCH, 8'hEE);
        bus_write(A_STRB, 8'h00);
        bus_write(A_KEY, 8'h55);
        bus_write(A_KEY, 8'hAA);
        bus_write(A_CTRL, C_WEN | C_PROG | C_GO);
        repeat (PROG_CYCLES - 8) @(negedge clk);
        chk_reg("R12 still busy", A_CTRL, C_WEN | C_PROG | C_GO | C_ERR);
        @(negedge clk);
        chk_reg("R12 not extended", A_CTRL, C_WEN | C_PROG | C_DONE);
        for (int i = 0; i < 8; i++) expect_mem("R6 strobe ignored", 2'd1, 16'(48 + i), 8'h40 + 8'(i));
        drain();

        // R8 erase row 1 leaves row 0 alone
        start_op(C_WEN | C_ERASE | C_PROG, 16'h007A);
        wait_op();
        expect_mem("R8 row1 lo", 2'd1, 16'h0040, 8'hFF);
        expect_mem("R8 row1 hi", 2'd1, 16'h007F, 8'hFF);
        expect_mem("R8 row0 kept", 2'd1, 16'h0037, 8'h47);
        drain();

        // R9 reset aborts a command
        fill_hold(8'h50);
        start_op(C_WEN, 16'h0000);
        wait_op();
        bus_write(A_CTRL, C_WEN);
        fill_hold(8'h60);
        start_op(C_WEN, 16'h0000);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_reg("R9 err kept", A_CTRL, C_ERR);
        chk("R9 irq", {7'd0, irq_done}, 8'h00);
        for (int i = 0; i < 8; i++) expect_mem("R9 store unchanged", 2'd0, 16'(i), 8'h50 + 8'(i));
        drain();
        bus_write(A_CTRL, C_WEN);
        fill_hold(8'h70);
        start_op(C_WEN, 16'h0000);
        wait_op();
        chk_reg("R9 err cleared", A_CTRL, C_WEN | C_DONE);
        for (int i = 0; i < 8; i++) expect_mem("R9 later write", 2'd0, 16'(i), 8'h70 + 8'(i));
        drain();

        bus_read(A_CTRL, d);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule